// File: doc/BRIEF.md
# Control-Flow Target Resolver

This block settles the outcome of one control-transfer instruction inside a processor's execute stage. It receives a decoded control-flow kind, the address of the current instruction, the two register operands and the immediate and target fields cut from the instruction word. From these it produces a taken flag, the address of the next instruction to fetch, and a request to write a return address into the register file.

Three ways of forming a target are supported. A conditional branch adds a signed word offset to the sequential address. An absolute jump keeps the top bits of the current address and replaces the rest with the target field. A register-indirect jump takes its target from the first register operand. Both jump forms may also save the sequential address as a return address. Every output is pure combinational logic, valid in the same cycle as its inputs.

Top module: `branch_resolver`

## Requirements
- R1: With `cf_kind` = 8 (no transfer), `taken` is 0, `next_pc` is `pc`+4 and `link_we` is 0.
- R2: For `cf_kind` 0 (equal), 1 (not equal), 2 (less or equal), 3 (less than), 4 (greater or equal) and 5 (greater than), `rs_val` is compared as a signed 32-bit number against `rt_val`, or against zero when `zero_cmp` is 1. If the condition holds, `taken` is 1 and `next_pc` is `pc`+4 plus the sign-extended `imm16` shifted left by two. Otherwise `taken` is 0 and `next_pc` is `pc`+4.
- R3: Branch target arithmetic is modulo 2^32, so negative offsets move backwards and sums past the top of the address space wrap to low addresses.
- R4: With `cf_kind` = 6 (absolute jump), `taken` is 1 and `next_pc` is `{pc[31:28], target26, 2'b00}`.
- R5: With `cf_kind` = 7 (register jump), `taken` is 1 and `next_pc` is `rs_val`.
- R6: An absolute jump with `link_en` = 1 raises `link_we`, with `link_idx` = 31 and `link_val` = `pc`+4. `rd_idx` has no effect on it.
- R7: A register jump with `link_en` = 1 and a nonzero `rd_idx` raises `link_we`, with `link_idx` = `rd_idx` and `link_val` = `pc`+4.
- R8: A link request whose destination is register 0 leaves `link_we` at 0.
- R9: For the conditional kinds 0 to 5, `link_en` has no effect: `link_we` stays 0.
- R10: The unused `cf_kind` codes 9 to 15 behave exactly like code 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cf_kind | input | 4 | Control-flow kind (codes listed in R1, R2, R4, R5) |
| zero_cmp | input | 1 | Compare `rs_val` against zero instead of `rt_val` |
| link_en | input | 1 | Request a return-address write |
| pc | input | 32 | Address of the current instruction |
| rs_val | input | 32 | First register operand; target of register jumps |
| rt_val | input | 32 | Second register operand |
| imm16 | input | 16 | Signed word offset for branches |
| target26 | input | 26 | Word target field for absolute jumps |
| rd_idx | input | 5 | Link destination for register jumps |
| taken | output | 1 | Control transfer happens |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Write the return address |
| link_idx | output | 5 | Destination register of the return address |
| link_val | output | 32 | Return address (`pc`+4) |

## Verification
Every output is due in the same cycle its inputs are applied: no register lies between any input and any output. The bench therefore drives each stimulus just after a rising clock edge and reads the outputs at the following falling edge, half a period later, when all combinational paths have settled. The clock only paces the stimulus and the watchdog and never reaches the block.

// File: rtl/branch_resolver_pkg.sv
// Package: shared encodings for the control-flow target resolver.
// Assumes the kind field is four bits wide and that codes above
// KIND_NONE are treated as "no transfer".
package branch_resolver_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        KIND_EQ   = 4'd0,
        KIND_NE   = 4'd1,
        KIND_LE   = 4'd2,
        KIND_LT   = 4'd3,
        KIND_GE   = 4'd4,
        KIND_GT   = 4'd5,
        KIND_JMP  = 4'd6,
        KIND_JREG = 4'd7,
        KIND_NONE = 4'd8
    } cf_kind_e;

    // True for the two unconditional kinds.
    function automatic logic is_jump_kind(input logic [KIND_W-1:0] k);
        return (k == KIND_JMP) || (k == KIND_JREG);
    endfunction

endpackage

// File: rtl/bt_compare.sv
// Module: bt_compare
// Evaluates the branch condition for the six conditional kinds.
// Assumes signed two's-complement operands; any other kind yields 0.
module bt_compare #(
    parameter int XLEN = 32
) (
    input  logic [branch_resolver_pkg::KIND_W-1:0] kind,
    input  logic                                   zero_cmp,
    input  logic [XLEN-1:0]                        lhs,
    input  logic [XLEN-1:0]                        rhs_reg,
    output logic                                   cond_true
);
    import branch_resolver_pkg::*;

    logic [XLEN-1:0] rhs;
    logic            is_eq;
    logic            is_lt;

    // Select the right-hand operand and form the two base relations.
    always_comb begin
        rhs   = zero_cmp ? '0 : rhs_reg;
        is_eq = (lhs == rhs);
        is_lt = ($signed(lhs) < $signed(rhs));
    end

    // Map the kind onto the base relations.
    always_comb begin
        case (kind)
            KIND_EQ: cond_true = is_eq;
            KIND_NE: cond_true = !is_eq;
            KIND_LE: cond_true = is_lt || is_eq;
            KIND_LT: cond_true = is_lt;
            KIND_GE: cond_true = !is_lt;
            KIND_GT: cond_true = !(is_lt || is_eq);
            default: cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/bt_target.sv
// Module: bt_target
// Forms the candidate addresses: sequential, PC-relative branch,
// region-preserving absolute jump and register-indirect jump.
// Assumes instructions are INSN_BYTES wide and word aligned.
module bt_target #(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int TGT_W      = 26,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  reg_target,
    input  logic [IMM_W-1:0] imm,
    input  logic [TGT_W-1:0] tgt,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_pc,
    output logic [XLEN-1:0]  abs_pc,
    output logic [XLEN-1:0]  reg_pc
);
    localparam int SHIFT    = $clog2(INSN_BYTES);
    localparam int SEXT_W   = XLEN - IMM_W - SHIFT;
    localparam int REGION_W = XLEN - TGT_W - SHIFT;

    logic [XLEN-1:0] br_off;

    // Sequential address and sign-extended, scaled branch offset.
    always_comb begin
        seq_pc = pc + XLEN'(INSN_BYTES);
        br_off = {{SEXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
        br_pc  = seq_pc + br_off;
    end

    // Absolute target: keep the region bits of pc when any are left.
    generate
        if (REGION_W > 0) begin : g_region
            assign abs_pc = {pc[XLEN-1 -: REGION_W], tgt, {SHIFT{1'b0}}};
        end else begin : g_flat
            assign abs_pc = XLEN'({tgt, {SHIFT{1'b0}}});
        end
    endgenerate

    // Register-indirect target passes through unchanged.
    assign reg_pc = reg_target;

endmodule

// File: rtl/bt_link.sv
// Module: bt_link
// Builds the return-address write request for the two jump kinds.
// Assumes register 0 is hard-wired and must never be written.
module bt_link #(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic [branch_resolver_pkg::KIND_W-1:0] kind,
    input  logic                                   link_en,
    input  logic [RIDX_W-1:0]                      rd,
    input  logic [XLEN-1:0]                        seq_pc,
    output logic                                   we,
    output logic [RIDX_W-1:0]                      idx,
    output logic [XLEN-1:0]                        val
);
    import branch_resolver_pkg::*;

    // Pick the destination and gate the write.
    always_comb begin
        idx = (kind == KIND_JMP) ? RIDX_W'(LINK_REG) : rd;
        we  = link_en && is_jump_kind(kind) && (idx != '0);
        val = seq_pc;
    end

endmodule

// File: rtl/branch_resolver.sv
// Module: branch_resolver (top)
// Resolves one control-flow instruction: taken flag, next address
// and return-address write request, all combinational.
// Assumes decoded inputs are stable for the whole evaluation.
module branch_resolver #(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int TGT_W      = 26,
    parameter int RIDX_W     = 5,
    parameter int INSN_BYTES = 4,
    parameter int LINK_REG   = 31
) (
    input  logic [branch_resolver_pkg::KIND_W-1:0] cf_kind,
    input  logic                                   zero_cmp,
    input  logic                                   link_en,
    input  logic [XLEN-1:0]                        pc,
    input  logic [XLEN-1:0]                        rs_val,
    input  logic [XLEN-1:0]                        rt_val,
    input  logic [IMM_W-1:0]                       imm16,
    input  logic [TGT_W-1:0]                       target26,
    input  logic [RIDX_W-1:0]                      rd_idx,
    output logic                                   taken,
    output logic [XLEN-1:0]                        next_pc,
    output logic                                   link_we,
    output logic [RIDX_W-1:0]                      link_idx,
    output logic [XLEN-1:0]                        link_val
);
    import branch_resolver_pkg::*;

    logic            cond_true;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] abs_pc;
    logic [XLEN-1:0] reg_pc;

    bt_compare #(.XLEN(XLEN)) u_cmp (
        .kind      (cf_kind),
        .zero_cmp  (zero_cmp),
        .lhs       (rs_val),
        .rhs_reg   (rt_val),
        .cond_true (cond_true)
    );

    bt_target #(
        .XLEN       (XLEN),
        .IMM_W      (IMM_W),
        .TGT_W      (TGT_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_tgt (
        .pc         (pc),
        .reg_target (rs_val),
        .imm        (imm16),
        .tgt        (target26),
        .seq_pc     (seq_pc),
        .br_pc      (br_pc),
        .abs_pc     (abs_pc),
        .reg_pc     (reg_pc)
    );

    bt_link #(
        .XLEN     (XLEN),
        .RIDX_W   (RIDX_W),
        .LINK_REG (LINK_REG)
    ) u_link (
        .kind    (cf_kind),
        .link_en (link_en),
        .rd      (rd_idx),
        .seq_pc  (seq_pc),
        .we      (link_we),
        .idx     (link_idx),
        .val     (link_val)
    );

    // Choose the next address according to kind and condition.
    always_comb begin
        case (cf_kind)
            KIND_JMP: begin
                taken   = 1'b1;
                next_pc = abs_pc;
            end
            KIND_JREG: begin
                taken   = 1'b1;
                next_pc = reg_pc;
            end
            default: begin
                taken   = cond_true;
                next_pc = cond_true ? br_pc : seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/branch_resolver_chk.sv
// Module: branch_resolver_chk
// Checker bound to branch_resolver; relates its ports with
// immediate assertions, skipped while any input is unknown.
module branch_resolver_chk #(
    parameter int XLEN   = 32,
    parameter int TGT_W  = 26,
    parameter int RIDX_W = 5
) (
    input logic [branch_resolver_pkg::KIND_W-1:0] cf_kind,
    input logic                                   link_en,
    input logic [XLEN-1:0]                        pc,
    input logic [XLEN-1:0]                        rs_val,
    input logic                                   taken,
    input logic [XLEN-1:0]                        next_pc,
    input logic                                   link_we,
    input logic [RIDX_W-1:0]                      link_idx,
    input logic [XLEN-1:0]                        link_val
);
    import branch_resolver_pkg::*;

    localparam int REGION_W = XLEN - TGT_W - 2;

    logic known;
    logic is_cond;

    // Flag settled inputs and conditional kinds.
    always_comb begin
        known   = !$isunknown({cf_kind, link_en, pc, rs_val});
        is_cond = (cf_kind <= KIND_GT);
    end

    // Port relations that must hold for every input combination.
    always_comb begin
        if (known) begin
            AST_NONE_FALLTHRU: assert (is_cond || is_jump_kind(cf_kind) || (!taken && next_pc == pc + XLEN'(4))) else $error("none kind moved pc"); // R1
            AST_NOT_TAKEN_SEQ: assert (taken || next_pc == pc + XLEN'(4)) else $error("not taken but not sequential"); // R2
            AST_JUMP_TAKEN: assert (!is_jump_kind(cf_kind) || taken) else $error("jump not taken"); // R4
            AST_JMP_REGION: assert (cf_kind != KIND_JMP || (next_pc[XLEN-1 -: REGION_W] == pc[XLEN-1 -: REGION_W] && next_pc[1:0] == 2'b00)) else $error("jump left region"); // R4
            AST_JREG_TARGET: assert (cf_kind != KIND_JREG || next_pc == rs_val) else $error("register jump target"); // R5
            AST_LINK_VALUE: assert (!link_we || link_val == pc + XLEN'(4)) else $error("link value"); // R6
            AST_LINK_NOT_ZERO: assert (!link_we || link_idx != '0) else $error("link to register 0"); // R8
            AST_LINK_JUMPS_ONLY: assert (!link_we || (is_jump_kind(cf_kind) && link_en)) else $error("link outside jump"); // R9
        end
    end

endmodule

bind branch_resolver branch_resolver_chk #(
    .XLEN   (XLEN),
    .TGT_W  (TGT_W),
    .RIDX_W (RIDX_W)
) u_chk (
    .cf_kind  (cf_kind),
    .link_en  (link_en),
    .pc       (pc),
    .rs_val   (rs_val),
    .taken    (taken),
    .next_pc  (next_pc),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val)
);

// File: tb/branch_resolver_bench.sv
// Bench for branch_resolver: a vector table walked by one loop, then
// directed corner cases. Inputs change after a rising edge, outputs
// are read at the next falling edge.
module branch_resolver_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  cf_kind;
    logic        zero_cmp;
    logic        link_en;
    logic [31:0] pc;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm16;
    logic [25:0] target26;
    logic [4:0]  rd_idx;
    logic        taken;
    logic [31:0] next_pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;

    branch_resolver u_branch_resolver (
        .cf_kind  (cf_kind),
        .zero_cmp (zero_cmp),
        .link_en  (link_en),
        .pc       (pc),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm16    (imm16),
        .target26 (target26),
        .rd_idx   (rd_idx),
        .taken    (taken),
        .next_pc  (next_pc),
        .link_we  (link_we),
        .link_idx (link_idx),
        .link_val (link_val)
    );

    typedef struct packed {
        logic [3:0]  kind;
        logic        zc;
        logic        lk;
        logic [31:0] pc;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [15:0] imm;
        logic [25:0] tgt;
        logic [4:0]  rd;
        logic        e_taken;
        logic [31:0] e_next;
        logic        e_we;
        logic [4:0]  e_idx;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 1'b0, 32'h0040_1000, 32'd5, 32'd5, 16'h0010, 26'd0, 5'd0, 1'b1, 32'h0040_1044, 1'b0, 5'd0, 8'd2},
        '{4'd0, 1'b0, 1'b0, 32'h0040_1000, 32'd5, 32'd6, 16'h0010, 26'd0, 5'd0, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd2},
        '{4'd1, 1'b0, 1'b0, 32'h0040_1000, 32'd5, 32'd6, 16'hFFFF, 26'd0, 5'd0, 1'b1, 32'h0040_1000, 1'b0, 5'd0, 8'd3},
        '{4'd3, 1'b0, 1'b0, 32'h0040_1000, 32'hFFFF_FFFF, 32'd1, 16'h0002, 26'd0, 5'd0, 1'b1, 32'h0040_100C, 1'b0, 5'd0, 8'd2},
        '{4'd3, 1'b0, 1'b0, 32'h0040_1000, 32'd1, 32'hFFFF_FFFF, 16'h0002, 26'd0, 5'd0, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd2},
        '{4'd2, 1'b1, 1'b0, 32'h0040_1000, 32'd0, 32'd9, 16'h0001, 26'd0, 5'd0, 1'b1, 32'h0040_1008, 1'b0, 5'd0, 8'd2},
        '{4'd2, 1'b1, 1'b0, 32'h0040_1000, 32'd1, 32'd9, 16'h0001, 26'd0, 5'd0, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd2},
        '{4'd5, 1'b1, 1'b0, 32'h0040_1000, 32'h8000_0000, 32'd0, 16'h0001, 26'd0, 5'd0, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd2},
        '{4'd5, 1'b1, 1'b0, 32'h0040_1000, 32'd7, 32'd100, 16'h8000, 26'd0, 5'd0, 1'b1, 32'h003E_1004, 1'b0, 5'd0, 8'd3},
        '{4'd4, 1'b0, 1'b0, 32'h0040_1000, 32'd3, 32'd3, 16'h0003, 26'd0, 5'd0, 1'b1, 32'h0040_1010, 1'b0, 5'd0, 8'd2},
        '{4'd4, 1'b0, 1'b0, 32'h0040_1000, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 16'h0003, 26'd0, 5'd0, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd2},
        '{4'd1, 1'b1, 1'b0, 32'h0040_1000, 32'd0, 32'd3, 16'h0004, 26'd0, 5'd0, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd2},
        '{4'd0, 1'b1, 1'b0, 32'h0040_1000, 32'd0, 32'd3, 16'h0004, 26'd0, 5'd0, 1'b1, 32'h0040_1014, 1'b0, 5'd0, 8'd2},
        '{4'd0, 1'b1, 1'b0, 32'hFFFF_FFF8, 32'd0, 32'd0, 16'h0004, 26'd0, 5'd0, 1'b1, 32'h0000_000C, 1'b0, 5'd0, 8'd3},
        '{4'd6, 1'b0, 1'b0, 32'hA040_1000, 32'd0, 32'd0, 16'h0000, 26'h012_3456, 5'd0, 1'b1, 32'hA048_D158, 1'b0, 5'd0, 8'd4},
        '{4'd6, 1'b0, 1'b1, 32'h0040_1000, 32'd0, 32'd0, 16'h0000, 26'h3FF_FFFF, 5'd7, 1'b1, 32'h0FFF_FFFC, 1'b1, 5'd31, 8'd6},
        '{4'd7, 1'b0, 1'b0, 32'h0040_1000, 32'h1234_5678, 32'd0, 16'h0000, 26'd0, 5'd4, 1'b1, 32'h1234_5678, 1'b0, 5'd0, 8'd5},
        '{4'd7, 1'b0, 1'b1, 32'h0040_1000, 32'h0000_2000, 32'd0, 16'h0000, 26'd0, 5'd9, 1'b1, 32'h0000_2000, 1'b1, 5'd9, 8'd7},
        '{4'd7, 1'b0, 1'b1, 32'h0040_1000, 32'h0000_2000, 32'd0, 16'h0000, 26'd0, 5'd0, 1'b1, 32'h0000_2000, 1'b0, 5'd0, 8'd8},
        '{4'd0, 1'b0, 1'b1, 32'h0040_1000, 32'd4, 32'd4, 16'h0001, 26'd0, 5'd12, 1'b1, 32'h0040_1008, 1'b0, 5'd0, 8'd9},
        '{4'd8, 1'b0, 1'b1, 32'h0040_1000, 32'd4, 32'd4, 16'h0001, 26'd5, 5'd12, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd1},
        '{4'd12, 1'b0, 1'b0, 32'h0040_1000, 32'd4, 32'd4, 16'h0001, 26'd5, 5'd12, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd10},
        '{4'd15, 1'b1, 1'b1, 32'h0040_1000, 32'd0, 32'd4, 16'h0001, 26'd5, 5'd12, 1'b0, 32'h0040_1004, 1'b0, 5'd0, 8'd10},
        '{4'd6, 1'b0, 1'b1, 32'h0040_1000, 32'd0, 32'd0, 16'h0000, 26'd0, 5'd0, 1'b1, 32'h0000_0000, 1'b1, 5'd31, 8'd6}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Compare one value and report a mismatch.
    task automatic check(input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one stimulus after a rising edge; outputs settle by the falling edge.
    task automatic drive(input vec_t v);
        @(posedge clk);
        cf_kind  = v.kind;
        zero_cmp = v.zc;
        link_en  = v.lk;
        pc       = v.pc;
        rs_val   = v.rs;
        rt_val   = v.rt;
        imm16    = v.imm;
        target26 = v.tgt;
        rd_idx   = v.rd;
        @(negedge clk);
    endtask

    // Full check of one vector against its expectations.
    task automatic run_vec(input vec_t v);
        drive(v);
        check("taken", int'(v.req), {31'd0, taken}, {31'd0, v.e_taken});
        check("next_pc", int'(v.req), next_pc, v.e_next);
        check("link_we", int'(v.req), {31'd0, link_we}, {31'd0, v.e_we});
        if (v.e_we) begin
            check("link_idx", int'(v.req), {27'd0, link_idx}, {27'd0, v.e_idx});
            check("link_val", int'(v.req), link_val, v.pc + 32'd4);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        vec_t d;
        cf_kind = 4'd8; zero_cmp = 1'b0; link_en = 1'b0;
        pc = 32'h0000_0100; rs_val = '0; rt_val = '0;
        imm16 = '0; target26 = '0; rd_idx = '0;
        @(negedge clk);
        // Idle state with the no-transfer kind (R1).
        check("idle taken", 1, {31'd0, taken}, 32'd0);
        check("idle next_pc", 1, next_pc, 32'h0000_0104);

        // Table walk covering R1 to R10.
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R2 corner: equal negative operands, LE taken but LT not.
        d = '{4'd2, 1'b0, 1'b0, 32'h0000_2000, 32'hFFFF_FFFB, 32'hFFFF_FFFB, 16'h0002, 26'd0, 5'd0, 1'b1, 32'h0000_200C, 1'b0, 5'd0, 8'd2};
        run_vec(d);
        d.kind = 4'd3; d.e_taken = 1'b0; d.e_next = 32'h0000_2004;
        run_vec(d);
        // R2 corner: equal operands, GE taken but GT not.
        d.kind = 4'd4; d.e_taken = 1'b1; d.e_next = 32'h0000_200C;
        run_vec(d);
        d.kind = 4'd5; d.e_taken = 1'b0; d.e_next = 32'h0000_2004;
        run_vec(d);
        // R2/R3 corner: most negative vs most positive, signed order.
        d = '{4'd3, 1'b0, 1'b0, 32'h0000_2000, 32'h8000_0000, 32'h7FFF_FFFF, 16'h7FFF, 26'd0, 5'd0, 1'b1, 32'h0002_2000, 1'b0, 5'd0, 8'd2};
        run_vec(d);
        // R9: link request on a not-taken branch stays silent.
        d = '{4'd1, 1'b0, 1'b1, 32'h0000_2000, 32'd3, 32'd3, 16'h0002, 26'd0, 5'd31, 1'b0, 32'h0000_2004, 1'b0, 5'd0, 8'd9};
        run_vec(d);
        // R10: every unused kind code acts as no transfer.
        for (int k = 9; k < 16; k++) begin
            d = '{4'(k), 1'b0, 1'b1, 32'h0000_3000, 32'd1, 32'd1, 16'h0008, 26'd3, 5'd6, 1'b0, 32'h0000_3004, 1'b0, 5'd0, 8'd10};
            run_vec(d);
        end
        // R5/R7: register jump to an address outside the pc region, with link.
        d = '{4'd7, 1'b0, 1'b1, 32'h1000_0000, 32'hF000_0010, 32'd0, 16'h0000, 26'd0, 5'd30, 1'b1, 32'hF000_0010, 1'b1, 5'd30, 8'd7};
        run_vec(d);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule